// File: doc/BRIEF.md
# Lane Reduction Accumulator

This block sits behind a vector multiplier. Each accepted cycle it takes a vector of signed product lanes and sign-extends every lane to the accumulator width. It then folds the vector in two pairwise adder stages: the first halves the lane count and the second halves it again. The folded lanes are added to, or subtracted from, one lane-wise operand vector, and the result is stored in an accumulator register. The operand vector is picked from the stored accumulator, an upshift input or a cascade input.

In forward mode the second fold is skipped, and the low half of the first-stage lanes goes straight to the accumulate step. The accumulator has one register per lane, changes only on an accepted input, and can be cleared synchronously. The product, upshift and cascade vectors come in as flat buses, with lane k at bits [k*W +: W] for a lane width W. With the default parameters there are 32 product lanes of 36 bits and 8 accumulator lanes of 48 bits.

Top module: `lane_reduce_acc`

## Requirements
- R1: While rst_n is low, and in the first cycle after release, every acc_o lane reads zero.
- R2: The first fold gives 16 intermediate lanes. Intermediate lane j is the sum of the sign-extended product lanes 2j and 2j+1.
- R3: With fwd_mode=0, reduced lane i is the sum of intermediate lanes 2i and 2i+1, which equals the sum of product lanes 4i to 4i+3.
- R4: With fwd_mode=1, reduced lane i is intermediate lane i for i in 0..7. Intermediate lanes 8..15 have no effect.
- R5: src_sel=0 takes the stored accumulator as the operand.
- R6: src_sel=1 takes ups_i as the operand, lane by lane.
- R7: src_sel=2 takes cas_i as the operand, lane by lane.
- R8: With sub_en=0 the new lane is operand plus reduced lane. With sub_en=1 it is operand minus reduced lane.
- R9: All sums and differences wrap modulo 2^48 per lane. Carries never cross into the next lane.
- R10: With in_valid=0 and clear=0, acc_o keeps its value whatever the other inputs are.
- R11: clear=1 sets every lane to zero on the next edge and takes priority over in_valid.
- R12: src_sel=3 behaves as src_sel=0.
- R13: Product lanes are signed two's complement. A negative product lowers the lane sum.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Accepts the current inputs into the accumulator |
| clear | input | 1 | Synchronous zeroing of the accumulator |
| fwd_mode | input | 1 | 1 skips the second fold |
| sub_en | input | 1 | 1 subtracts the reduced lanes from the operand |
| src_sel | input | 2 | Operand source: 0 stored, 1 upshift, 2 cascade, 3 stored |
| prod_i | input | PROD_LANES*PROD_W (1152) | Signed product lanes |
| ups_i | input | OUT_LANES*ACC_W (384) | Upshift operand lanes |
| cas_i | input | OUT_LANES*ACC_W (384) | Cascade operand lanes |
| acc_o | output | OUT_LANES*ACC_W (384) | Accumulator lanes |

## Verification
The hardest case to reach from the ports is wrap-around at the 48-bit lane edge. Products are at most 36 bits wide, so the only way to get there is through an operand that is already near the limit. The stimulus therefore puts lanes of all ones on ups_i and small positive products on prod_i, and checks that each lane wraps to a small value while its neighbour is left alone. In the same way, forward mode is only proven if the upper intermediate lanes carry values that would visibly change the result if they leaked through, so those product lanes are loaded with large values.

// File: rtl/lra_pkg.sv
package lra_pkg;
   typedef enum logic [1:0] {
      SRC_ACC = 2'd0,
      SRC_UPS = 2'd1,
      SRC_CAS = 2'd2,
      SRC_RSV = 2'd3
   } src_sel_e;
endpackage

// File: rtl/lra_sext.sv
module lra_sext #(
   parameter int LANES  = 32,
   parameter int IN_W   = 36,
   parameter int OUT_W  = 48
) (
   input  logic [LANES*IN_W-1:0]  lanes_i,
   output logic [LANES*OUT_W-1:0] lanes_o
);
   initial begin
      if (IN_W > OUT_W) $fatal(1, "lra_sext: IN_W exceeds OUT_W");
   end

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      if (IN_W == OUT_W) begin : g_same
         assign lanes_o[g*OUT_W +: OUT_W] = lanes_i[g*IN_W +: IN_W];
      end else begin : g_ext
         assign lanes_o[g*OUT_W +: OUT_W] =
            {{(OUT_W-IN_W){lanes_i[g*IN_W+IN_W-1]}}, lanes_i[g*IN_W +: IN_W]};
      end
   end
endmodule

// File: rtl/lra_pair_reduce.sv
module lra_pair_reduce #(
   parameter int IN_LANES = 32,
   parameter int W        = 48
) (
   input  logic [IN_LANES*W-1:0]     lanes_i,
   output logic [(IN_LANES/2)*W-1:0] lanes_o
);
   localparam int OUT_LANES = IN_LANES / 2;

   initial begin
      if (IN_LANES % 2 != 0) $fatal(1, "lra_pair_reduce: odd lane count");
   end

   for (genvar g = 0; g < OUT_LANES; g++) begin : g_pair
      assign lanes_o[g*W +: W] = lanes_i[(2*g)*W +: W] + lanes_i[(2*g+1)*W +: W];
   end
endmodule

// File: rtl/lra_acc_update.sv
module lra_acc_update
   import lra_pkg::*;
#(
   parameter int LANES = 8,
   parameter int W     = 48
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_en,
   input  logic             clear,
   input  logic             sub_en,
   input  logic [1:0]       src_sel,
   input  logic [LANES*W-1:0] red_i,
   input  logic [LANES*W-1:0] ups_i,
   input  logic [LANES*W-1:0] cas_i,
   output logic [LANES*W-1:0] acc_o
);
   logic [LANES*W-1:0] acc_q;
   logic [LANES*W-1:0] acc_d;

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      logic [W-1:0] opnd;
      always_comb begin
         unique case (src_sel)
            SRC_UPS: opnd = ups_i[g*W +: W];
            SRC_CAS: opnd = cas_i[g*W +: W];
            default: opnd = acc_q[g*W +: W];
         endcase
      end
      assign acc_d[g*W +: W] = sub_en ? (opnd - red_i[g*W +: W])
                                      : (opnd + red_i[g*W +: W]);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_q <= '0;
      end else if (clear) begin
         acc_q <= '0;
      end else if (load_en) begin
         acc_q <= acc_d;
      end
   end

   assign acc_o = acc_q;
endmodule

// File: rtl/lane_reduce_acc.sv
module lane_reduce_acc #(
   parameter int PROD_LANES = 32,
   parameter int PROD_W     = 36,
   parameter int ACC_W      = 48,
   localparam int MID_LANES = PROD_LANES / 2,
   localparam int OUT_LANES = PROD_LANES / 4
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       in_valid,
   input  logic                       clear,
   input  logic                       fwd_mode,
   input  logic                       sub_en,
   input  logic [1:0]                 src_sel,
   input  logic [PROD_LANES*PROD_W-1:0] prod_i,
   input  logic [OUT_LANES*ACC_W-1:0] ups_i,
   input  logic [OUT_LANES*ACC_W-1:0] cas_i,
   output logic [OUT_LANES*ACC_W-1:0] acc_o
);
   initial begin
      if (PROD_LANES % 4 != 0) $fatal(1, "lane_reduce_acc: PROD_LANES must be a multiple of 4");
      if (PROD_W > ACC_W)      $fatal(1, "lane_reduce_acc: PROD_W exceeds ACC_W");
   end

   logic [PROD_LANES*ACC_W-1:0] ext_lanes;
   logic [MID_LANES*ACC_W-1:0]  mid_lanes;
   logic [OUT_LANES*ACC_W-1:0]  fold_lanes;
   logic [OUT_LANES*ACC_W-1:0]  red_lanes;

   lra_sext #(.LANES(PROD_LANES), .IN_W(PROD_W), .OUT_W(ACC_W)) sext_i (
      .lanes_i (prod_i),
      .lanes_o (ext_lanes)
   );

   lra_pair_reduce #(.IN_LANES(PROD_LANES), .W(ACC_W)) fold1_i (
      .lanes_i (ext_lanes),
      .lanes_o (mid_lanes)
   );

   lra_pair_reduce #(.IN_LANES(MID_LANES), .W(ACC_W)) fold2_i (
      .lanes_i (mid_lanes),
      .lanes_o (fold_lanes)
   );

   assign red_lanes = fwd_mode ? mid_lanes[OUT_LANES*ACC_W-1:0] : fold_lanes;

   lra_acc_update #(.LANES(OUT_LANES), .W(ACC_W)) acc_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .load_en (in_valid),
      .clear   (clear),
      .sub_en  (sub_en),
      .src_sel (src_sel),
      .red_i   (red_lanes),
      .ups_i   (ups_i),
      .cas_i   (cas_i),
      .acc_o   (acc_o)
   );
endmodule

// File: rtl/lra_checker.sv
module lra_checker #(
   parameter int PROD_LANES = 32,
   parameter int PROD_W     = 36,
   parameter int ACC_W      = 48,
   localparam int OUT_LANES = PROD_LANES / 4
) (
   input logic                         clk,
   input logic                         rst_n,
   input logic                         in_valid,
   input logic                         clear,
   input logic                         sub_en,
   input logic [1:0]                   src_sel,
   input logic [PROD_LANES*PROD_W-1:0] prod_i,
   input logic [OUT_LANES*ACC_W-1:0]   ups_i,
   input logic [OUT_LANES*ACC_W-1:0]   cas_i,
   input logic [OUT_LANES*ACC_W-1:0]   acc_o
);
   logic no_prod;
   assign no_prod = (prod_i == '0);

   assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (!in_valid && !clear) |=> $stable(acc_o));

   assert_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
      clear |=> (acc_o == '0));

   assert_old_src_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !clear && src_sel == 2'd0 && no_prod) |=> $stable(acc_o));

   assert_ups_src_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !clear && src_sel == 2'd1 && no_prod) |=> (acc_o == $past(ups_i)));

   assert_cas_src_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !clear && src_sel == 2'd2 && no_prod) |=> (acc_o == $past(cas_i)));

   assert_sub_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !clear && sub_en && src_sel == 2'd2 && no_prod) |=> (acc_o == $past(cas_i)));

   assert_rsv_src_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !clear && src_sel == 2'd3 && no_prod) |=> $stable(acc_o));
endmodule

bind lane_reduce_acc lra_checker #(
   .PROD_LANES (PROD_LANES),
   .PROD_W     (PROD_W),
   .ACC_W      (ACC_W)
) chk_i (
   .clk      (clk),
   .rst_n    (rst_n),
   .in_valid (in_valid),
   .clear    (clear),
   .sub_en   (sub_en),
   .src_sel  (src_sel),
   .prod_i   (prod_i),
   .ups_i    (ups_i),
   .cas_i    (cas_i),
   .acc_o    (acc_o)
);

// File: tb/lane_reduce_acc_tb_top.sv
module lane_reduce_acc_tb_top;
   localparam int PL = 32;
   localparam int PW = 36;
   localparam int AW = 48;
   localparam int OL = PL / 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic in_valid = 1'b0, clear = 1'b0, fwd_mode = 1'b0, sub_en = 1'b0;
   logic [1:0] src_sel = 2'd0;
   logic [PL*PW-1:0] prod_flat;
   logic [OL*AW-1:0] ups_flat, cas_flat, acc_o;

   logic [PW-1:0] p   [PL];
   logic [AW-1:0] ups [OL];
   logic [AW-1:0] cas [OL];
   logic [AW-1:0] model [OL];

   int checks = 0;
   int failures = 0;

   always #10 clk = ~clk;

   always_comb begin
      for (int k = 0; k < PL; k++) prod_flat[k*PW +: PW] = p[k];
      for (int k = 0; k < OL; k++) begin
         ups_flat[k*AW +: AW] = ups[k];
         cas_flat[k*AW +: AW] = cas[k];
      end
   end

   lane_reduce_acc #(.PROD_LANES(PL), .PROD_W(PW), .ACC_W(AW)) dut_i (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .clear(clear),
      .fwd_mode(fwd_mode), .sub_en(sub_en), .src_sel(src_sel),
      .prod_i(prod_flat), .ups_i(ups_flat), .cas_i(cas_flat), .acc_o(acc_o)
   );

   function automatic logic [AW-1:0] sx(input int k);
      return {{(AW-PW){p[k][PW-1]}}, p[k]};
   endfunction

   function automatic logic [AW-1:0] red(input int i, input bit fwd);
      if (fwd) return sx(2*i) + sx(2*i+1);
      return sx(4*i) + sx(4*i+1) + sx(4*i+2) + sx(4*i+3);
   endfunction

   task automatic compare(input string req);
      for (int i = 0; i < OL; i++) begin
         checks++;
         if (acc_o[i*AW +: AW] !== model[i]) begin
            failures++;
            $display("FAIL %s lane %0d actual=%h expected=%h", req, i, acc_o[i*AW +: AW], model[i]);
         end
      end
   endtask

   task automatic step(input bit v, input bit c, input bit f, input logic [1:0] s,
                       input bit sb, input string req);
      logic [AW-1:0] op;
      @(negedge clk);
      in_valid = v; clear = c; fwd_mode = f; src_sel = s; sub_en = sb;
      for (int i = 0; i < OL; i++) begin
         op = (s == 2'd1) ? ups[i] : (s == 2'd2) ? cas[i] : model[i];
         if (c) model[i] = '0;
         else if (v) model[i] = sb ? op - red(i, f) : op + red(i, f);
      end
      @(posedge clk); #1;
      compare(req);
      @(negedge clk);
      in_valid = 1'b0; clear = 1'b0;
   endtask

   task automatic set_prod_ramp(input int base);
      for (int k = 0; k < PL; k++) p[k] = PW'(base + k * 3);
   endtask

   task automatic t_reset();
      for (int i = 0; i < OL; i++) model[i] = '0;
      #1; compare("R1 in reset");
      @(negedge clk); rst_n = 1'b1;
      @(posedge clk); #1; compare("R1 after release");
   endtask

   task automatic t_fold();  // R2 R3
      set_prod_ramp(5);
      step(1'b1, 1'b0, 1'b0, 2'd0, 1'b0, "R3 two folds");
   endtask

   task automatic t_forward();  // R4: upper intermediate lanes hold big values
      step(1'b0, 1'b1, 1'b0, 2'd0, 1'b0, "R11 clear");
      set_prod_ramp(1);
      for (int k = 16; k < PL; k++) p[k] = PW'(64'h7_0000_0000 + k);
      step(1'b1, 1'b0, 1'b1, 2'd0, 1'b0, "R4 forward R2");
   endtask

   task automatic t_old();
      set_prod_ramp(100);
      step(1'b1, 1'b0, 1'b0, 2'd0, 1'b0, "R5 old acc");
   endtask

   task automatic t_ups();
      for (int i = 0; i < OL; i++) ups[i] = AW'(64'h1000_0000_0000 + i * 7);
      set_prod_ramp(9);
      step(1'b1, 1'b0, 1'b0, 2'd1, 1'b0, "R6 upshift");
   endtask

   task automatic t_cas();
      for (int i = 0; i < OL; i++) cas[i] = AW'(64'h0200_0000_0000 + i * 11);
      set_prod_ramp(2);
      step(1'b1, 1'b0, 1'b0, 2'd2, 1'b0, "R7 cascade");
   endtask

   task automatic t_sub();
      set_prod_ramp(40);
      step(1'b1, 1'b0, 1'b0, 2'd2, 1'b1, "R8 subtract");
      step(1'b1, 1'b0, 1'b1, 2'd0, 1'b1, "R8 subtract fwd");
   endtask

   task automatic t_wrap();
      for (int i = 0; i < OL; i++) ups[i] = '1;
      for (int k = 0; k < PL; k++) p[k] = PW'(1);
      step(1'b1, 1'b0, 1'b0, 2'd1, 1'b0, "R9 wrap");
      for (int i = 0; i < OL; i++) begin
         checks++;
         if (acc_o[i*AW +: AW] !== AW'(3)) begin
            failures++;
            $display("FAIL R9 lane %0d actual=%h expected=%h", i, acc_o[i*AW +: AW], AW'(3));
         end
      end
   endtask

   task automatic t_hold();
      set_prod_ramp(777);
      for (int i = 0; i < OL; i++) begin ups[i] = AW'(i); cas[i] = AW'(i + 50); end
      step(1'b0, 1'b0, 1'b1, 2'd1, 1'b1, "R10 hold");
   endtask

   task automatic t_clear();
      set_prod_ramp(3);
      step(1'b1, 1'b1, 1'b0, 2'd1, 1'b0, "R11 clear over valid");
   endtask

   task automatic t_rsv();
      set_prod_ramp(21);
      step(1'b1, 1'b0, 1'b0, 2'd0, 1'b0, "R12 seed");
      step(1'b1, 1'b0, 1'b0, 2'd3, 1'b0, "R12 code 3 as stored");
   endtask

   task automatic t_neg();
      step(1'b0, 1'b1, 1'b0, 2'd0, 1'b0, "R11 clear");
      for (int k = 0; k < PL; k++) p[k] = (k % 2 == 0) ? PW'(-(k * 1000 + 5)) : PW'(k);
      step(1'b1, 1'b0, 1'b0, 2'd0, 1'b0, "R13 negative products");
      step(1'b1, 1'b0, 1'b1, 2'd2, 1'b1, "R13 negative sub fwd");
   endtask

   initial begin
      #(20 * 200000);
      failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      for (int k = 0; k < PL; k++) p[k] = '0;
      for (int i = 0; i < OL; i++) begin ups[i] = '0; cas[i] = '0; end
      repeat (3) @(posedge clk);
      t_reset();
      t_fold();
      t_forward();
      t_old();
      t_ups();
      t_cas();
      t_sub();
      t_wrap();
      t_hold();
      t_clear();
      t_rsv();
      t_neg();
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule